// File: doc/BRIEF.md
# Interleaved Multi-Row Multiply-Accumulate

This block forms several dot products at once, one per row: c_r is the sum over t of a_{r,t}·b_{r,t}. It has one multiplier and an adder whose result takes LAT cycles to come back. If all of one row's terms went through that adder in sequence, each addition would have to wait for the previous one. To avoid that wait, the block takes operands term by term across the rows. Every row receives its term t before any row receives term t+1. Additions that follow each other in time then belong to different rows and never depend on each other.

Operand pairs arrive on a valid/ready stream in term-major order. A register file holds one partial sum per row. It is read where the adder takes its inputs and written where the adder's latency ends. A row's first term ignores the stored value and adds zero to its product, so each vector starts from a clean sum. When there are fewer rows than LAT, the input stalls only for the cycles the dependency needs. When there are at least LAT rows, the input never stalls on the dependency. Finished sums leave in row order on a valid/ready output stream. Backpressure on that stream freezes the whole pipeline.

Top module: `vmac_interleave`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: Each result equals the sum, over the TERMS terms of that row, of the product of the row's two operands. Operands are W-bit two's complement. The sum is a two's complement AW-bit value, where AW = 2W + clog2(TERMS+1).
- R3: Operands are taken in term-major order: the k-th accepted pair of a vector (counting from 0) belongs to row k mod ROWS and term floor(k/ROWS).
- R4: The results of a vector leave in row order 0, 1, …, ROWS-1, and out_row carries the index of the row being presented.
- R5: When ROWS < LAT, a vector whose input is offered without gaps, with out_ready held at 1, is stalled (in_valid high and in_ready low) for exactly (TERMS-1)·(LAT-ROWS) cycles.
- R6: When ROWS ≥ LAT, in_ready goes low only while an output is waiting with out_ready low.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_row hold their values and in_ready is 0.
- R8: A row's sum contains nothing from any earlier vector: the first term of every row replaces the stored partial sum instead of adding to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take the pair this cycle |
| in_a | input | W | First operand, signed |
| in_b | input | W | Second operand, signed |
| out_valid | output | 1 | A finished row sum is presented |
| out_ready | input | 1 | Consumer takes the sum this cycle |
| out_data | output | AW | Finished row sum, signed |
| out_row | output | RW | Row index of out_data |

## Verification
If a partial sum is read too early, or the hazard check misses a row that is still in flight, the row shows a stale sum. That wrong value reaches out_data about LAT cycles after the row's last term. The bench computes every sum from a reference and compares it there. A wrong first-term bypass shows at the next vector as a sum that still carries the previous vector's value. A wrong stall count shows directly at in_ready, within the same vector. A broken freeze under backpressure shows at once, as an output that changes, or as in_ready rising while an output is waiting.

// File: rtl/vmac_interleave.sv
`timescale 1ns/1ps
module vmac_interleave #(
  parameter int W = 8,
  parameter int ROWS = 4,
  parameter int TERMS = 3,
  parameter int LAT = 6,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TW = (TERMS > 1) ? $clog2(TERMS) : 1,
  localparam int AW = 2*W + $clog2(TERMS+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data,
  output logic [RW-1:0] out_row
);
  logic [AW-1:0] acc [ROWS];
  logic [RW-1:0] row_q;
  logic [TW-1:0] term_q;
  logic [LAT-1:0] s_vld, s_last;
  logic [RW-1:0] s_row [LAT];
  logic [AW-1:0] s_sum [LAT];
  logic [LAT-2:0] clash;
  logic [2*W-1:0] prod;
  logic [AW-1:0] addend, sum_in;
  logic en, fire, hazard;

  assign en = !out_valid || out_ready;

  for (genvar k = 0; k < LAT-1; k++) begin : g_clash
    assign clash[k] = s_vld[k] && (s_row[k] == row_q);
  end

  assign hazard   = (term_q != '0) && (|clash);
  assign in_ready = en && !hazard;
  assign fire     = in_valid && in_ready;

  assign prod   = $signed(in_a) * $signed(in_b);
  assign addend = (term_q == '0) ? '0 : acc[row_q];
  assign sum_in = addend + {{(AW-2*W){prod[2*W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      term_q <= '0;
    end else if (fire) begin
      if (row_q == RW'(ROWS-1)) begin
        row_q  <= '0;
        term_q <= (term_q == TW'(TERMS-1)) ? '0 : term_q + 1'b1;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s_vld <= '0;
    else if (en) s_vld <= {s_vld[LAT-2:0], fire};
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s_last   <= {s_last[LAT-2:0], term_q == TW'(TERMS-1)};
      s_row[0] <= row_q;
      s_sum[0] <= sum_in;
      for (int k = 1; k < LAT; k++) begin
        s_row[k] <= s_row[k-1];
        s_sum[k] <= s_sum[k-1];
      end
      if (s_vld[LAT-2]) acc[s_row[LAT-2]] <= s_sum[LAT-2];
    end
  end

  assign out_valid = s_vld[LAT-1] && s_last[LAT-1];
  assign out_data  = s_sum[LAT-1];
  assign out_row   = s_row[LAT-1];
endmodule

// File: rtl/vmac_interleave_chk.sv
`timescale 1ns/1ps
module vmac_interleave_chk #(
  parameter int ROWS = 4,
  parameter int LAT = 6,
  parameter int RW = 2,
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_data,
  input logic [RW-1:0] out_row
);
  logic [RW-1:0] exp_row;

  always_ff @(posedge clk) begin
    if (rst) exp_row <= '0;
    else if (out_valid && out_ready)
      exp_row <= (exp_row == RW'(ROWS-1)) ? '0 : exp_row + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  a_r4_row_order: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_row == exp_row));

  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_row)));

  a_r7_input_frozen: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_no_bubble: assert property (@(posedge clk) disable iff (rst)
    ((ROWS >= LAT) && !in_ready) |-> (out_valid && !out_ready));
endmodule

bind vmac_interleave vmac_interleave_chk #(.ROWS(ROWS), .LAT(LAT), .RW(RW), .AW(AW)) u_chk (.*);

// File: tb/vmac_interleave_bench.sv
`timescale 1ns/1ps
module vmac_interleave_bench;
  localparam int W = 8, ROWS = 4, TERMS = 3, LAT = 6, N = ROWS*TERMS;
  localparam int AW = 2*W + $clog2(TERMS+1);
  localparam int WR = 8, WT = 2, WN = WR*WT, WAW = 2*W + $clog2(WT+1);

  localparam logic signed [7:0] TA [3][N] = '{
    '{8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1, 8'sd1},
    '{-8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128,
      -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128},
    '{8'sd3, -8'sd7, 8'sd0, 8'sd12, -8'sd5, 8'sd9, 8'sd100, -8'sd1, 8'sd2, 8'sd2, -8'sd60, 8'sd11}
  };
  localparam logic signed [7:0] TB [3][N] = '{
    '{8'sd1, 8'sd2, 8'sd3, 8'sd4, 8'sd5, 8'sd6, 8'sd7, 8'sd8, 8'sd9, 8'sd10, 8'sd11, 8'sd12},
    '{-8'sd128, 8'sd127, -8'sd1, 8'sd0, -8'sd128, 8'sd127, -8'sd1, 8'sd0,
      -8'sd128, 8'sd127, -8'sd1, 8'sd0},
    '{-8'sd4, 8'sd6, 8'sd77, -8'sd9, 8'sd13, 8'sd0, -8'sd3, 8'sd127, 8'sd50, -8'sd8, 8'sd1, 8'sd4}
  };

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic in_valid = 0, out_ready = 0, in_ready, out_valid;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic [AW-1:0] out_data;
  logic [1:0] out_row;

  logic w_valid = 0, w_oready = 0, w_ready, w_ovalid;
  logic [W-1:0] w_a = '0, w_b = '0;
  logic [WAW-1:0] w_data;
  logic [2:0] w_row;

  vmac_interleave #(.W(W), .ROWS(ROWS), .TERMS(TERMS), .LAT(LAT)) u_vmac_interleave (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_row(out_row));

  vmac_interleave #(.W(W), .ROWS(WR), .TERMS(WT), .LAT(LAT)) u_wide (
    .clk(clk), .rst(rst), .in_valid(w_valid), .in_ready(w_ready), .in_a(w_a), .in_b(w_b),
    .out_valid(w_ovalid), .out_ready(w_oready), .out_data(w_data), .out_row(w_row));

  int checks = 0, errors = 0;
  logic signed [7:0] va [N];
  logic signed [7:0] vb [N];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int bp_in, input int bp_out, output int stalls, output int holdbad);
    longint exp [ROWS];
    int sent = 0, got = 0, cyc = 0;
    stalls = 0; holdbad = 0;
    for (int r = 0; r < ROWS; r++) exp[r] = 0;
    for (int i = 0; i < N; i++) exp[i % ROWS] += longint'(va[i]) * longint'(vb[i]);
    while (got < ROWS && cyc < 3000) begin
      @(negedge clk);
      if (sent < N) begin
        in_valid = ($urandom % 100) >= bp_in;
        in_a = va[sent]; in_b = vb[sent];
      end else in_valid = 0;
      out_ready = ($urandom % 100) >= bp_out;
      #1;
      if (in_valid && !in_ready) stalls++;
      if (out_valid && !out_ready && in_ready) holdbad++;
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        chk(out_row == 2'(got), "R4", "row order", out_row, got);
        chk($signed(out_data) == exp[got], "R2 R3 R8", "row sum", $signed(out_data), exp[got]);
        got++;
      end
      cyc++;
    end
    chk(got == ROWS, "R2", "watchdog: results received", got, ROWS);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st, hb;
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk) rst = 0;
    #1;
    chk(!out_valid && in_ready, "R1", "idle after reset", {out_valid, in_ready}, 1);

    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < N; i++) begin va[i] = TA[s][i]; vb[i] = TB[s][i]; end
      run_vec(0, 0, st, hb);
      chk(st == (TERMS-1)*(LAT-ROWS), "R5", "dependency stall cycles", st, (TERMS-1)*(LAT-ROWS));
    end

    for (int n = 0; n < 10; n++) begin
      for (int i = 0; i < N; i++) begin va[i] = 8'($urandom); vb[i] = 8'($urandom); end
      run_vec(30, 40, st, hb);
      chk(hb == 0, "R7", "in_ready high while output waits", hb, 0);
    end

    for (int i = 0; i < N; i++) begin va[i] = TA[0][i]; vb[i] = TB[0][i]; end
    run_vec(0, 0, st, hb);

    begin
      int sent = 0, got = 0, cyc = 0, wst = 0;
      while (got < WR && cyc < 500) begin
        @(negedge clk);
        w_valid = sent < WN;
        w_a = 8'((sent % WR) + 1); w_b = 8'((sent / WR) + 1);
        w_oready = 1;
        #1;
        if (w_valid && !w_ready) wst++;
        if (w_valid && w_ready) sent++;
        if (w_ovalid) begin
          chk(w_row == 3'(got), "R4", "wide row order", w_row, got);
          chk($signed(w_data) == (got + 1) * 3, "R2", "wide row sum", $signed(w_data), (got + 1) * 3);
          got++;
        end
        cyc++;
      end
      chk(got == WR, "R6", "wide results received", got, WR);
      chk(wst == 0, "R6", "wide stall cycles", wst, 0);
      @(negedge clk) w_valid = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule